// File: doc/BRIEF.md
# First-Order Coarse/Fine Requantizer

This block sits in the digital feedback path of a multibit sigma-delta converter that uses a two-step quantizer. Each sample arrives as a coarse code and a fine code. The block joins them into one unsigned word, with the coarse code as the most significant part. It then regenerates the coarse/fine split with a first-order error-feedback loop.

The new coarse code drives the coarse element-rotation bank. The new fine code is one bit wider than the incoming fine code, signed, and drives the fine bank. Because each code is shaped on its own, any gain mismatch between the two DAC banks leaks coarse quantization error only in a first-order high-pass form. No higher-order loop is used. The default split is four coarse bits and four fine bits.

The loop works like this. The truncation error held from the previous accepted sample is added to the current word. The upper bits of that sum become the coarse code, and the lower bits become the next stored error. Outputs are registered and appear one cycle after a valid sample. Cycles without a valid sample leave both the outputs and the loop state untouched.

Top module: `requant_top`

## Requirements
- R1: While reset is asserted, outValid, outCoarse and outFine are zero and the stored error is zero. The first sample after reset is therefore requantized with zero error.
- R2: The input word is W = inCoarse * 2^NF + inFine. inCoarse forms the most significant NC bits and inFine the least significant NF bits.
- R3: With stored error E, let S = W + E. When floor(S / 2^NF) is at most 2^NC - 1, outCoarse equals floor(S / 2^NF).
- R4: When floor(S / 2^NF) equals 2^NC, outCoarse saturates at 2^NC - 1 and the next stored error is clamped to 2^NF - 1.
- R5: outFine is a two's complement value of NF+1 bits, equal to W - outCoarse * 2^NF. It always lies within -(2^NF - 1) to +(2^NF - 1).
- R6: Without saturation, the next stored error is S mod 2^NF, which is the low NF bits of S.
- R7: In a cycle where inValid is low, outCoarse, outFine and the stored error keep their values, and outValid is low in the next cycle.
- R8: outValid in a cycle equals inValid in the previous cycle. The codes for a sample appear in the cycle after that sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a sample present on the inputs |
| inCoarse | input | NC | Coarse code from the two-step quantizer |
| inFine | input | NF | Fine code from the two-step quantizer |
| outValid | output | 1 | Marks fresh codes on the outputs |
| outCoarse | output | NC | Requantized coarse code |
| outFine | output | NF+1 | Signed residual fine code |

## Verification
The bench builds the block with NC = 3 and NF = 2. This gives a 32-value input word and only four possible stored-error states, so a long deterministic sweep visits every word under every error state many times over. Runs of the largest word drive the sum past full scale, which exercises saturation and the clamped error. Gaps in inValid check that outputs and loop state hold, and the model tracks the error independently to predict every coarse and fine code.

// File: rtl/requant_pkg.sv
package requant_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;   // accept the sample on the inputs this cycle
    logic armed;  // at least one edge seen since reset (history is valid)
  } reqStrobeT;
endpackage

// File: rtl/requant_ctrl.sv
module requant_ctrl
  import requant_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output reqStrobeT strobe,
  output logic      outValid
);
  logic armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      armedQ   <= 1'b0;
    end else begin
      outValid <= inValid;
      armedQ   <= 1'b1;
    end
  end

  always_comb begin
    strobe.load  = inValid;
    strobe.armed = armedQ;
  end

  // R8: output valid follows input valid by exactly one cycle
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (outValid == $past(inValid)));
endmodule

// File: rtl/requant_dp.sv
module requant_dp
  import requant_pkg::*;
#(
  parameter int NC = 4,
  parameter int NF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  reqStrobeT        strobe,
  input  logic [NC-1:0]    inCoarse,
  input  logic [NF-1:0]    inFine,
  output logic [NC-1:0]    outCoarse,
  output logic [NF:0]      outFine
);
  localparam int N = NC + NF;
  localparam logic [NF-1:0] ErrMax = {NF{1'b1}};
  localparam int FineLim = (1 << NF) - 1;

  logic [N-1:0]  word;
  logic [N:0]    sum;
  logic [NC:0]   coarseRaw;
  logic [NF-1:0] sumLow;
  logic          sat;
  logic [NF-1:0] errQ, errNext;
  logic [NC-1:0] coarseNext;
  logic [NF:0]   fineNext;

  always_comb begin
    word      = {inCoarse, inFine};
    sum       = {1'b0, word} + {{(NC + 1){1'b0}}, errQ};
    coarseRaw = sum[N:NF];
    sumLow    = sum[NF-1:0];
    sat       = coarseRaw[NC];
    if (sat) begin
      coarseNext = {NC{1'b1}};
      errNext    = ErrMax;
      fineNext   = {1'b0, inFine};
    end else begin
      coarseNext = coarseRaw[NC-1:0];
      errNext    = sumLow;
      fineNext   = {1'b0, sumLow} - {1'b0, errQ};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ      <= '0;
      outCoarse <= '0;
      outFine   <= '0;
    end else if (strobe.load) begin
      errQ      <= errNext;
      outCoarse <= coarseNext;
      outFine   <= fineNext;
    end
  end

  // R5: fine code stays within its symmetric signed range
  assert_fine_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (int'($signed(outFine)) <= FineLim) && (int'($signed(outFine)) >= -FineLim));

  // R5: registered codes rebuild the word that was presented
  assert_rebuild_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && $past(strobe.load)) |->
      (int'(outCoarse) * (1 << NF) + int'($signed(outFine)) ==
       int'($past({inCoarse, inFine}))));

  // R3: coarse output never drops below, nor exceeds by more than one, the input coarse
  assert_coarse_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && $past(strobe.load)) |->
      ((int'(outCoarse) >= int'($past(inCoarse))) &&
       (int'(outCoarse) <= int'($past(inCoarse)) + 1)));

  // R7: idle cycles leave the outputs untouched
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && !$past(strobe.load)) |-> ($stable(outCoarse) && $stable(outFine)));
endmodule

// File: rtl/requant_top.sv
module requant_top
  import requant_pkg::*;
#(
  parameter int NC = 4,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [NC-1:0] inCoarse,
  input  logic [NF-1:0] inFine,
  output logic          outValid,
  output logic [NC-1:0] outCoarse,
  output logic [NF:0]   outFine
);
  reqStrobeT strobe;

  requant_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  requant_dp #(.NC(NC), .NF(NF)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inCoarse  (inCoarse),
    .inFine    (inFine),
    .outCoarse (outCoarse),
    .outFine   (outFine)
  );
endmodule

// File: tb/test_requant_top.sv
module test_requant_top;
  localparam int NC = 3;
  localparam int NF = 2;
  localparam int CMAX = (1 << NC) - 1;
  localparam int EMAX = (1 << NF) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [NC-1:0] inCoarse = '0;
  logic [NF-1:0] inFine = '0;
  logic outValid;
  logic [NC-1:0] outCoarse;
  logic [NF:0] outFine;

  int nTests = 0;
  int nFail = 0;
  int modelErr = 0;
  int expC = 0;
  int expF = 0;
  int expV = 0;
  int satHits = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  requant_top #(.NC(NC), .NF(NF)) i_requant_top (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inCoarse(inCoarse), .inFine(inFine),
    .outValid(outValid), .outCoarse(outCoarse), .outFine(outFine)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOutputs();
    check("R8 outValid", int'(outValid), expV);
    check("R3/R4 outCoarse", int'(outCoarse), expC);
    check("R5/R6 outFine", int'($signed(outFine)), expF);
  endtask

  // Called at a falling edge: checks the previous cycle, then drives a new one
  task automatic step(input bit v, input int w);
    @(negedge clk);
    checkOutputs();
    inValid  = v;
    inCoarse = NC'(w >> NF);
    inFine   = NF'(w);
    expV = v;
    if (v) begin
      int s, c;
      s = w + modelErr;           // R2 word with error added
      c = s >> NF;
      if (c > CMAX) begin         // R4 saturation and clamp
        c = CMAX;
        modelErr = EMAX;
        satHits++;
      end else begin
        modelErr = s & EMAX;      // R6 low bits kept
      end
      expC = c;
      expF = w - c * (1 << NF);   // R5 residual
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid reset", int'(outValid), 0);
    check("R1 outCoarse reset", int'(outCoarse), 0);
    check("R1 outFine reset", int'($signed(outFine)), 0);
    rstN = 1'b1;
    // R1: first sample sees zero error: word 6 -> coarse 1, fine 2
    step(1'b1, 6);
    @(negedge clk);
    check("R1 first coarse", int'(outCoarse), 1);
    check("R1 first fine", int'($signed(outFine)), 2);
    check("R8 first valid", int'(outValid), 1);
    inValid = 1'b0;
    expV = 0;
    // R7: idle gap, outputs hold and error holds
    step(1'b0, 31);
    step(1'b0, 0);
    // Sweep of all words with gaps (R2, R3, R5, R6, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      int w;
      w = (i * 7 + (i / 32) * 3) % 32;
      step((i % 5) != 4, w);
    end
    // R4: run of full-scale words forces saturation
    for (int i = 0; i < 12; i++) step(1'b1, 31);
    // After saturation, error is clamped: word 4 -> 4+3=7 -> coarse 1, fine 0
    step(1'b1, 4);
    step(1'b1, 0);
    step(1'b0, 0);
    step(1'b0, 0);
    check("R4 saturation reached", satHits > 0 ? 1 : 0, 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule